// File: doc/BRIEF.md
# Cache-Line Read Streaming Engine

This block takes inbound memory read requests from a serial-link port and cuts each one, in arrival order, into 64-byte cache-line pieces. Every piece takes a slot in a small line buffer. A slot goes through two round trips on a command/response interface toward the coherency and data manager: a prefetch that must be acknowledged, then a fetch that returns the line's data. After the data has been handed back to the port as a completion beat, a fetch-done command frees the slot.

The number of slots is the credit limit on outstanding lines. A line that finds the buffer completely empty skips the prefetch round trip and is fetched at once. Completion beats always leave in request order, whatever order the responses come back in. Each beat carries the request tag and a flag that marks the request's final line. Every edge of the block uses a valid/ready pair. Commands and responses name the slot they refer to, so responses may arrive in any order.

Top module: `line_stream_reader`

## Requirements
- R1: A request with start address A and byte length L (L of 0 counts as one byte) is split into ((A mod 64) + max(L,1) - 1) / 64 + 1 lines. The lines' command addresses are consecutive 64-byte aligned values starting at A with its low 6 bits cleared.
- R2: Requests are taken one at a time in arrival order. reqReady is low from the cycle after a request is accepted until its last line has been given a slot.
- R3: At most MAX_LINES lines are held at once. The held count rises when a line gets a slot, falls when its fetch-done command is issued, and changes by at most one per cycle.
- R4: A line that gets a slot while at least one other line is held is sent first as a prefetch (cmdKind 0). Its fetch (cmdKind 1) is issued only after a response with rspKind 0 (acknowledge) has arrived for its slot.
- R5: A line that gets a slot while the buffer is empty gets a fetch as its first command, with no prefetch.
- R6: One completion beat is produced per line, strictly in request and line order. The beat carries the tag of the line's request, the data from the response with rspKind 1 for that line, and cplLast set only on the request's final line.
- R7: Once a line's completion beat is accepted, a fetch-done command (cmdKind 2) for its slot is issued. Only then is the slot free for a new line.
- R8: While cmdValid is high and cmdReady is low, cmdKind, cmdSlot and cmdAddr hold their values and cmdValid stays high.
- R9: While cplValid is high and cplReady is low, cplTag, cplData and cplLast hold their values and cplValid stays high.
- R10: A response for a slot that is not waiting for that kind of response is ignored. It produces no completion and changes no stored data.
- R11: After reset, reqReady is high, and cmdValid and cplValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Request accepted when both high |
| reqAddr | input | ADDR_W | Byte start address |
| reqLen | input | LEN_W | Byte length |
| reqTag | input | TAG_W | Request tag returned with completions |
| cmdValid | output | 1 | Command offered |
| cmdReady | input | 1 | Command taken when both high |
| cmdKind | output | 2 | 0 prefetch, 1 fetch, 2 fetch-done |
| cmdSlot | output | log2(MAX_LINES) | Buffer slot the command refers to |
| cmdAddr | output | ADDR_W | Line-aligned address of that slot |
| rspValid | input | 1 | Response offered |
| rspReady | output | 1 | Always high; responses are never stalled |
| rspKind | input | 1 | 0 prefetch acknowledge, 1 fetch data |
| rspSlot | input | log2(MAX_LINES) | Slot the response belongs to |
| rspData | input | DATA_W | Line data for a fetch response |
| cplValid | output | 1 | Completion beat offered |
| cplReady | input | 1 | Beat taken when both high |
| cplTag | output | TAG_W | Tag of the beat's request |
| cplData | output | DATA_W | Line data |
| cplLast | output | 1 | Beat is the request's final line |

## Verification
A slot stuck in the wrong phase either stalls the stream, so the command or completion port goes quiet, or lets data through that was never fetched. The bench therefore compares every completion beat's tag, data and last flag against its own per-line list. A reordering or a misplaced slot shows up as a miscompare on the very next beat. The credit counter and the bypass decision are checked through the exact command sequence seen while responses are withheld. Because the bench answers in last-in first-out order, any shortcut in ordering becomes visible within a few cycles.

// File: rtl/line_stream_pkg.sv
package line_stream_pkg;

  localparam int LINE_BYTES = 64;
  localparam int LINE_OFS_W = $clog2(LINE_BYTES);

  typedef enum logic [2:0] {
    SLOT_FREE,
    SLOT_NEED_PF,
    SLOT_WAIT_ACK,
    SLOT_NEED_FETCH,
    SLOT_WAIT_DATA,
    SLOT_HAVE_DATA,
    SLOT_RETIRE
  } slotState_e;

  typedef enum logic [1:0] {
    CMD_PREFETCH = 2'd0,
    CMD_FETCH    = 2'd1,
    CMD_DONE     = 2'd2
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // load a new request
    logic alloc;  // write next line into a slot
    logic fill;   // store response data into a slot
  } dpStrobes_t;

endpackage

// File: rtl/line_stream_ctrl.sv
module line_stream_ctrl
  import line_stream_pkg::*;
#(
  parameter int MAX_LINES = 4,
  parameter int LINES_W   = 8,
  localparam int SLOT_W   = $clog2(MAX_LINES),
  localparam int COUNT_W  = $clog2(MAX_LINES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [LINES_W-1:0] reqLines,
  output logic               cmdValid,
  input  logic               cmdReady,
  output cmdKind_e           cmdKind,
  output logic [SLOT_W-1:0]  cmdSlot,
  input  logic               rspValid,
  output logic               rspReady,
  input  logic               rspKind,
  input  logic [SLOT_W-1:0]  rspSlot,
  output logic               cplValid,
  input  logic               cplReady,
  output dpStrobes_t         strobes,
  output logic [SLOT_W-1:0]  allocSlot,
  output logic               allocLast,
  output logic [SLOT_W-1:0]  headSlot,
  output logic [COUNT_W-1:0] lineOcc
);

  slotState_e slotState [MAX_LINES];
  logic [SLOT_W-1:0]  headPtr, tailPtr;
  logic [COUNT_W-1:0] occ;
  logic               splitting;
  logic [LINES_W-1:0] linesLeft;

  logic               holdValid;
  cmdKind_e           holdKind;
  logic [SLOT_W-1:0]  holdSlot;

  logic               fetchFound, pfFound, doneCand;
  logic [SLOT_W-1:0]  fetchSlot, pfSlot;
  logic               take, alloc, cmdFire, cplFire, ackHit, dataHit;

  assign reqReady  = !splitting;
  assign take      = reqValid && !splitting;
  assign alloc     = splitting && (occ < COUNT_W'(MAX_LINES));
  assign allocSlot = tailPtr;
  assign allocLast = (linesLeft == LINES_W'(1));
  assign headSlot  = headPtr;
  assign lineOcc   = occ;

  assign rspReady  = 1'b1;
  assign ackHit    = rspValid && !rspKind && (slotState[rspSlot] == SLOT_WAIT_ACK);
  assign dataHit   = rspValid &&  rspKind && (slotState[rspSlot] == SLOT_WAIT_DATA);

  assign cplValid  = (slotState[headPtr] == SLOT_HAVE_DATA);
  assign cplFire   = cplValid && cplReady;
  assign doneCand  = (slotState[headPtr] == SLOT_RETIRE);

  assign strobes.take  = take;
  assign strobes.alloc = alloc;
  assign strobes.fill  = dataHit;

  // oldest-first scan for lines waiting on a command
  always_comb begin
    logic [SLOT_W-1:0] idx;
    fetchFound = 1'b0;
    fetchSlot  = '0;
    pfFound    = 1'b0;
    pfSlot     = '0;
    for (int i = 0; i < MAX_LINES; i++) begin
      idx = headPtr + SLOT_W'(i);
      if (!fetchFound && slotState[idx] == SLOT_NEED_FETCH) begin
        fetchFound = 1'b1;
        fetchSlot  = idx;
      end
      if (!pfFound && slotState[idx] == SLOT_NEED_PF) begin
        pfFound = 1'b1;
        pfSlot  = idx;
      end
    end
  end

  // a stalled command is frozen in the hold registers
  always_comb begin
    cmdValid = 1'b1;
    cmdKind  = CMD_PREFETCH;
    cmdSlot  = pfSlot;
    if (holdValid) begin
      cmdKind = holdKind;
      cmdSlot = holdSlot;
    end else if (doneCand) begin
      cmdKind = CMD_DONE;
      cmdSlot = headPtr;
    end else if (fetchFound) begin
      cmdKind = CMD_FETCH;
      cmdSlot = fetchSlot;
    end else if (!pfFound) begin
      cmdValid = 1'b0;
    end
  end

  assign cmdFire = cmdValid && cmdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_LINES; i++) slotState[i] <= SLOT_FREE;
      headPtr   <= '0;
      tailPtr   <= '0;
      occ       <= '0;
      splitting <= 1'b0;
      linesLeft <= '0;
      holdValid <= 1'b0;
      holdKind  <= CMD_PREFETCH;
      holdSlot  <= '0;
    end else begin
      if (take) begin
        splitting <= 1'b1;
        linesLeft <= reqLines;
      end
      if (alloc) begin
        slotState[tailPtr] <= (occ == '0) ? SLOT_NEED_FETCH : SLOT_NEED_PF;
        tailPtr   <= tailPtr + 1'b1;
        linesLeft <= linesLeft - 1'b1;
        if (allocLast) splitting <= 1'b0;
      end
      if (cmdFire) begin
        case (cmdKind)
          CMD_PREFETCH: slotState[cmdSlot] <= SLOT_WAIT_ACK;
          CMD_FETCH:    slotState[cmdSlot] <= SLOT_WAIT_DATA;
          default:      slotState[cmdSlot] <= SLOT_FREE;
        endcase
      end
      if (ackHit)  slotState[rspSlot] <= SLOT_NEED_FETCH;
      if (dataHit) slotState[rspSlot] <= SLOT_HAVE_DATA;
      if (cplFire) slotState[headPtr] <= SLOT_RETIRE;
      if (cmdFire && cmdKind == CMD_DONE) headPtr <= headPtr + 1'b1;
      occ <= occ + COUNT_W'(alloc) - COUNT_W'(cmdFire && cmdKind == CMD_DONE);
      if (cmdFire) begin
        holdValid <= 1'b0;
      end else if (cmdValid) begin
        holdValid <= 1'b1;
        holdKind  <= cmdKind;
        holdSlot  <= cmdSlot;
      end
    end
  end

endmodule

// File: rtl/line_stream_dp.sv
module line_stream_dp
  import line_stream_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 64,
  parameter int MAX_LINES = 4,
  parameter int LINES_W   = 8,
  localparam int SLOT_W   = $clog2(MAX_LINES),
  localparam int LADDR_W  = ADDR_W - LINE_OFS_W,
  localparam int SPAN_W   = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [TAG_W-1:0]   reqTag,
  output logic [LINES_W-1:0] reqLines,
  input  logic [SLOT_W-1:0]  allocSlot,
  input  logic               allocLast,
  input  logic [SLOT_W-1:0]  rspSlot,
  input  logic [DATA_W-1:0]  rspData,
  input  logic [SLOT_W-1:0]  cmdSlot,
  input  logic [SLOT_W-1:0]  headSlot,
  output logic [ADDR_W-1:0]  cmdAddr,
  output logic [TAG_W-1:0]   cplTag,
  output logic [DATA_W-1:0]  cplData,
  output logic               cplLast
);

  logic [LADDR_W-1:0] nextLine;
  logic [TAG_W-1:0]   curTag;
  logic [LADDR_W-1:0] lineAddr [MAX_LINES];
  logic [TAG_W-1:0]   lineTag  [MAX_LINES];
  logic               lineLast [MAX_LINES];
  logic [DATA_W-1:0]  lineData [MAX_LINES];
  logic [SPAN_W-1:0]  lastByte;

  // offset of the request's final byte from the first line's base
  always_comb begin
    lastByte = SPAN_W'(reqAddr[LINE_OFS_W-1:0]);
    if (reqLen != '0) lastByte = lastByte + SPAN_W'(reqLen) - 1'b1;
    reqLines = LINES_W'(lastByte >> LINE_OFS_W) + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextLine <= '0;
      curTag   <= '0;
    end else if (strobes.take) begin
      nextLine <= reqAddr[ADDR_W-1:LINE_OFS_W];
      curTag   <= reqTag;
    end else if (strobes.alloc) begin
      nextLine <= nextLine + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.alloc) begin
      lineAddr[allocSlot] <= nextLine;
      lineTag[allocSlot]  <= curTag;
      lineLast[allocSlot] <= allocLast;
    end
    if (strobes.fill) lineData[rspSlot] <= rspData;
  end

  assign cmdAddr = {lineAddr[cmdSlot], {LINE_OFS_W{1'b0}}};
  assign cplTag  = lineTag[headSlot];
  assign cplData = lineData[headSlot];
  assign cplLast = lineLast[headSlot];

endmodule

// File: rtl/line_stream_reader.sv
module line_stream_reader
  import line_stream_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 64,
  parameter int MAX_LINES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [LEN_W-1:0]             reqLen,
  input  logic [TAG_W-1:0]             reqTag,
  output logic                         cmdValid,
  input  logic                         cmdReady,
  output logic [1:0]                   cmdKind,
  output logic [$clog2(MAX_LINES)-1:0] cmdSlot,
  output logic [ADDR_W-1:0]            cmdAddr,
  input  logic                         rspValid,
  output logic                         rspReady,
  input  logic                         rspKind,
  input  logic [$clog2(MAX_LINES)-1:0] rspSlot,
  input  logic [DATA_W-1:0]            rspData,
  output logic                         cplValid,
  input  logic                         cplReady,
  output logic [TAG_W-1:0]             cplTag,
  output logic [DATA_W-1:0]            cplData,
  output logic                         cplLast
);

  localparam int SLOT_W  = $clog2(MAX_LINES);
  localparam int COUNT_W = $clog2(MAX_LINES + 1);
  localparam int LINES_W = LEN_W - LINE_OFS_W + 2;

  dpStrobes_t         strobes;
  logic [LINES_W-1:0] reqLines;
  logic [SLOT_W-1:0]  allocSlot, headSlot;
  logic               allocLast;
  logic [COUNT_W-1:0] lineOcc;
  cmdKind_e           cmdKindE;

  assign cmdKind = cmdKindE;

  line_stream_ctrl #(.MAX_LINES(MAX_LINES), .LINES_W(LINES_W)) i_ctrl (
    .clk, .rstN, .reqValid, .reqReady, .reqLines,
    .cmdValid, .cmdReady, .cmdKind(cmdKindE), .cmdSlot,
    .rspValid, .rspReady, .rspKind, .rspSlot,
    .cplValid, .cplReady, .strobes, .allocSlot, .allocLast, .headSlot, .lineOcc
  );

  line_stream_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .MAX_LINES(MAX_LINES), .LINES_W(LINES_W)
  ) i_dp (
    .clk, .rstN, .strobes, .reqAddr, .reqLen, .reqTag, .reqLines,
    .allocSlot, .allocLast, .rspSlot, .rspData, .cmdSlot, .headSlot,
    .cmdAddr, .cplTag, .cplData, .cplLast
  );

endmodule

// File: rtl/line_stream_reader_chk.sv
module line_stream_reader_chk #(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 64,
  parameter int MAX_LINES = 4,
  localparam int SLOT_W   = $clog2(MAX_LINES),
  localparam int COUNT_W  = $clog2(MAX_LINES + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [1:0]         cmdKind,
  input logic [SLOT_W-1:0]  cmdSlot,
  input logic [ADDR_W-1:0]  cmdAddr,
  input logic               cplValid,
  input logic               cplReady,
  input logic [TAG_W-1:0]   cplTag,
  input logic [DATA_W-1:0]  cplData,
  input logic               cplLast,
  input logic [COUNT_W-1:0] lineOcc
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineOcc <= COUNT_W'(MAX_LINES));

  p_occ_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lineOcc == $past(lineOcc)) || (lineOcc == $past(lineOcc) + 1'b1) ||
    (lineOcc + 1'b1 == $past(lineOcc)));

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdKind) && $stable(cmdSlot) && $stable(cmdAddr));

  p_cpl_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cplValid && !cplReady |=> cplValid && $stable(cplTag) && $stable(cplData) && $stable(cplLast));

endmodule

bind line_stream_reader line_stream_reader_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .MAX_LINES(MAX_LINES)
) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind), .cmdSlot(cmdSlot),
  .cmdAddr(cmdAddr), .cplValid(cplValid), .cplReady(cplReady), .cplTag(cplTag),
  .cplData(cplData), .cplLast(cplLast), .lineOcc(lineOcc)
);

// File: tb/test_line_stream_reader.sv
`timescale 1ns/1ps
module test_line_stream_reader;

  localparam int ADDR_W = 32, LEN_W = 12, TAG_W = 8, DATA_W = 64, MAX_LINES = 4;
  localparam int SLOT_W = $clog2(MAX_LINES);
  localparam int NVEC = 8;
  // {addr, len, tag, expected line count}
  localparam logic [59:0] VEC [NVEC] = '{
    {32'h0000_1000, 12'd64,  8'h11, 8'd1},
    {32'h0000_1000, 12'd1,   8'h12, 8'd1},
    {32'h0000_103F, 12'd2,   8'h13, 8'd2},
    {32'h0000_2010, 12'd128, 8'h14, 8'd3},
    {32'h0000_3000, 12'd256, 8'h15, 8'd4},
    {32'h0000_4020, 12'd0,   8'h16, 8'd1},
    {32'h0000_5000, 12'd640, 8'h17, 8'd10},
    {32'h0000_6004, 12'd300, 8'h18, 8'd5}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic cmdValid, cmdReady = 0;
  logic [1:0] cmdKind;
  logic [SLOT_W-1:0] cmdSlot;
  logic [ADDR_W-1:0] cmdAddr;
  logic rspValid = 0, rspReady, rspKind = 0;
  logic [SLOT_W-1:0] rspSlot = '0;
  logic [DATA_W-1:0] rspData = '0;
  logic cplValid, cplReady = 0, cplLast;
  logic [TAG_W-1:0] cplTag;
  logic [DATA_W-1:0] cplData;

  always #2 clk = ~clk;

  line_stream_reader i_line_stream_reader (.*);

  int nChk = 0, nBad = 0, cyc = 0;
  // request queue and expected completions
  logic [ADDR_W-1:0] rqA [64]; logic [LEN_W-1:0] rqL [64]; logic [TAG_W-1:0] rqT [64];
  int rqWr = 0, rqRd = 0;
  logic [TAG_W-1:0] expTag [256]; logic [ADDR_W-1:0] expAddr [256]; logic expLast [256];
  int expWr = 0, expRd = 0, totalLines = 0, doneCnt = 0, beatCnt = 0;
  // stub state
  logic [SLOT_W-1:0] pSlot [64]; logic pKind [64]; logic [ADDR_W-1:0] pAddr [64];
  int pendN = 0;
  int logKind [256]; int logSlot [256]; logic [ADDR_W-1:0] logAddr [256];
  int logN = 0;
  bit stubOn = 0, cmdRdyOn = 0, cplRdyOn = 0, injectJunk = 0;
  int cmdDiv = 1, cplOfs = 1;
  logic [SLOT_W-1:0] junkSlot = '0;
  bit prevCmdStall = 0, prevCplStall = 0;
  logic [1:0] pK; logic [SLOT_W-1:0] pS; logic [ADDR_W-1:0] pA;
  logic [TAG_W-1:0] pT; logic [DATA_W-1:0] pD; logic pL;

  function automatic logic [DATA_W-1:0] dataOf(logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushReq(logic [ADDR_W-1:0] a, logic [LEN_W-1:0] l, logic [TAG_W-1:0] t);
    int lines = ((a % 64) + ((l == 0) ? 0 : l - 1)) / 64 + 1;
    rqA[rqWr] = a; rqL[rqWr] = l; rqT[rqWr] = t; rqWr++;
    for (int k = 0; k < lines; k++) begin
      expTag[expWr] = t;
      expAddr[expWr] = (a & ~ADDR_W'(63)) + ADDR_W'(64 * k);
      expLast[expWr] = (k == lines - 1);
      expWr++;
    end
    totalLines += lines;
  endtask

  task automatic step();
    if (prevCmdStall)
      check(cmdValid && cmdKind == pK && cmdSlot == pS && cmdAddr == pA, "R8 command hold",
            {cmdValid, cmdKind, cmdAddr}, {1'b1, pK, pA});
    if (prevCplStall)
      check(cplValid && cplTag == pT && cplData == pD && cplLast == pL, "R9 completion hold",
            cplData, pD);
    // request side
    reqValid = (rqRd < rqWr);
    if (reqValid) begin reqAddr = rqA[rqRd]; reqLen = rqL[rqRd]; reqTag = rqT[rqRd]; end
    if (reqValid && reqReady) rqRd++;
    // command side
    cmdReady = cmdRdyOn && ((cyc % cmdDiv) == 0);
    // response side (stub answers last-in first-out)
    rspValid = 0;
    if (injectJunk) begin
      rspValid = 1; rspKind = 1; rspSlot = junkSlot; rspData = '1; injectJunk = 0;
    end else if (stubOn && pendN > 0) begin
      pendN--;
      rspValid = 1; rspKind = pKind[pendN]; rspSlot = pSlot[pendN];
      rspData = dataOf(pAddr[pendN]);
    end
    if (cmdValid && cmdReady) begin
      logKind[logN] = int'(cmdKind); logSlot[logN] = int'(cmdSlot); logAddr[logN] = cmdAddr; logN++;
      if (cmdKind == 2'd2) doneCnt++;
      else begin
        pSlot[pendN] = cmdSlot; pKind[pendN] = (cmdKind == 2'd1); pAddr[pendN] = cmdAddr; pendN++;
      end
    end
    prevCmdStall = cmdValid && !cmdReady; pK = cmdKind; pS = cmdSlot; pA = cmdAddr;
    // completion side
    cplReady = cplRdyOn && (((cyc + cplOfs) % 3) != 0);
    if (cplValid && cplReady) begin
      beatCnt++;
      if (expRd >= expWr) check(0, "R6 unexpected beat", cplData, '0);
      else begin
        check(cplTag == expTag[expRd] && cplData == dataOf(expAddr[expRd]) && cplLast == expLast[expRd],
              "R6 beat order/content", {cplLast, cplTag, cplData[47:0]},
              {expLast[expRd], expTag[expRd], dataOf(expAddr[expRd])});
        expRd++;
      end
    end
    prevCplStall = cplValid && !cplReady; pT = cplTag; pD = cplData; pL = cplLast;
    @(posedge clk); #1; cyc++;
  endtask

  task automatic drain();
    int n = 0;
    while ((doneCnt < totalLines || rqRd < rqWr) && n < 20000) begin step(); n++; end
    repeat (4) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    // R11 reset state
    check(reqReady == 1, "R11 reqReady", reqReady, 1);
    check(cmdValid == 0, "R11 cmdValid", cmdValid, 0);
    check(cplValid == 0, "R11 cplValid", cplValid, 0);

    // R10: data for a free slot is ignored
    junkSlot = '0; injectJunk = 1;
    repeat (5) step();
    check(cplValid == 0 && cmdValid == 0, "R10 idle response", {cplValid, cmdValid}, 0);

    // R3/R4/R5: responses withheld, ten-line request
    cmdRdyOn = 1; cmdDiv = 1; cplRdyOn = 1;
    pushReq(32'h0000_8000, 12'd640, 8'h77);
    repeat (30) step();
    check(logN == MAX_LINES, "R3 lines issued under cap", logN, MAX_LINES);
    check(logKind[0] == 1, "R5 first line bypasses prefetch", logKind[0], 1);
    for (int i = 1; i < MAX_LINES; i++)
      check(logKind[i] == 0, "R4 later lines prefetch first", logKind[i], 0);
    for (int i = 0; i < MAX_LINES; i++)
      check(logAddr[i] == 32'h0000_8000 + 32'(64 * i), "R1 line address", logAddr[i], 32'h8000 + 64 * i);
    check(reqReady == 0, "R2 busy while splitting", reqReady, 0);
    // R10: data before the acknowledge must be ignored (later beat data proves it)
    junkSlot = SLOT_W'(logSlot[1]); injectJunk = 1;
    repeat (5) step();
    check(cplValid == 0 && logN == MAX_LINES, "R10 early data ignored", {cplValid, 8'(logN)}, MAX_LINES);
    stubOn = 1;
    drain();
    check(doneCnt == 10, "R7 fetch-done per line", doneCnt, 10);
    check(expRd == expWr, "R6 all beats delivered", expRd, expWr);
    check(reqReady == 1 && cmdValid == 0, "R7 buffer released", {reqReady, cmdValid}, 2'b10);

    // R2/R6: two back-to-back requests, responses reordered
    pushReq(32'h0000_9000, 12'd200, 8'h01);
    pushReq(32'h0000_A000, 12'd64, 8'h02);
    cmdDiv = 2; cplOfs = 2;
    drain();
    check(expRd == expWr, "R2 both requests completed in order", expRd, expWr);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      int startLog;
      cmdDiv = v % 3 + 1; cplOfs = v;
      beatCnt = 0; startLog = logN;
      pushReq(VEC[v][59:28], VEC[v][27:16], VEC[v][15:8]);
      drain();
      check(beatCnt == int'(VEC[v][7:0]), "R1 line count", beatCnt, VEC[v][7:0]);
      check(logKind[startLog] == 1, "R5 empty buffer bypass", logKind[startLog], 1);
      check(doneCnt == totalLines, "R7 done count", doneCnt, totalLines);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule